// File: doc/BRIEF.md
# SPI Byte Controller with Write-Collision Detection

This block is a byte-wide SPI peripheral that a processor drives through three small registers: control, status and data. Set to master, it generates the serial clock itself and shifts one byte out on MOSI while it captures a byte from MISO. Set to slave, it follows an external clock and select, and returns its loaded byte on MISO. Clock polarity and clock phase are selectable in both roles. Bits travel most significant first.

A data-register write that lands while a byte is in flight is thrown away, so the transfer on the wire completes untouched. The write is recorded in a collision flag. The collision window depends on the role and on the clock phase. In master mode it is the time the generated clock is shifting. In slave mode with phase 0 it is the whole time the select is low. In slave mode with phase 1 it runs from the first clock edge to the last sampled bit. Received bytes are placed in a holding buffer, so reads never collide.

Both status flags are cleared only by a read handshake: first a status read that sees a flag set, then a data-register read. An interrupt request follows the completion flag alone.

Top module: `spi_wcol_ctrl`

## Requirements
- R1: Register map: address 0 is control, 1 is status, 2 is data. Control bit0 selects master (1) or slave (0), bit1 is the idle clock level (polarity), bit2 is the clock phase, and bit3 enables the interrupt. Status bit7 is the completion flag and bit6 is the collision flag. A read returns its value in reg_rdata one cycle after reg_rd.
- R2: In master mode, a data write while idle starts a transfer. MOSI carries the byte MSB first. With phase 0, bits are sampled on leading clock edges; with phase 1, on trailing edges. The byte taken from MISO is returned by a later data read.
- R3: In master mode, a data write while the generated clock is shifting sets the collision flag and does not change the byte that is transmitted.
- R4: In slave mode with phase 0, a data write while the select is low sets the collision flag and is discarded. A write while the select is high loads the byte that is sent next.
- R5: In slave mode with phase 1, a data write with the select low but before the first clock edge is accepted without collision, and MISO stays undriven until that first edge. A write after the first edge and before the eighth sample collides and is discarded.
- R6: The completion flag is set on the eighth sampling edge. The interrupt output is high while the completion flag and the enable bit are both set, and it drops once the flag is cleared.
- R7: A collision never raises the interrupt output.
- R8: A status read that sees a flag set, followed by a data read, clears the flags that the status read saw.
- R9: A data write does not clear the collision flag.
- R10: In slave mode, MISO output enable is low whenever the select is high.
- R11: When a flag is set and cleared in the same cycle, it ends up set.
- R12: In slave mode, the byte shifted in on MOSI is returned by a data read after the transfer.
- R13: In master mode, the generated clock rests at the polarity level while no transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Completion interrupt request |
| sck_out | output | 1 | Serial clock generated in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| sck_in | input | 1 | Serial clock in for slave mode |
| mosi_in | input | 1 | Serial data in for slave mode |
| ss_n_in | input | 1 | Slave select, active low |
| miso_out | output | 1 | Serial data out for slave mode |
| miso_oe | output | 1 | Output enable for miso_out |

## Verification
The status flags can be written by two sources in one cycle: a new completion can be set by the eighth sampling edge at the same moment that a data read finishes a clearing handshake aimed at that flag. The bench leaves the previous completion pending and arms the handshake with a status read. It then starts a master transfer and issues the data read on the exact cycle of the eighth sample, which it computes from the clock divider (fifteen half periods after the write in phase 0). The result is judged by a later status read, which must still show the completion flag. Collisions are also injected in the middle of the serial stream in every role and phase, and the bench checks that the byte seen on the wire is the one loaded before the collision.

// File: rtl/spi_wc_pkg.sv
package spi_wc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_WCOL_BIT = 6;

  typedef struct packed {
    logic irq_en;
    logic cpha;
    logic cpol;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/spi_wc_sync.sv
module spi_wc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_wc_mclk.sv
module spi_wc_mclk #(
  parameter int HALF_DIV = 4,
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cpol,
  output logic sck,
  output logic lead,
  output logic trail,
  output logic busy
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EDGES = 2 * BITS;
  localparam int IW = $clog2(EDGES);

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          edge_hit;

  assign edge_hit = busy && (cnt == CW'(HALF_DIV - 1));
  assign lead     = edge_hit && !idx[0];
  assign trail    = edge_hit && idx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sck  <= 1'b0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
      sck  <= cpol;
    end else if (busy) begin
      if (edge_hit) begin
        cnt <= '0;
        sck <= ~sck;
        if (idx == IW'(EDGES - 1)) begin
          idx  <= '0;
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end

  // R13: clock rests at polarity level when idle
  a_r13_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && cpol == $past(cpol)) |-> sck == cpol);
  // R2: a transfer ends only after the full edge count
  a_r2_full_edges: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (idx == '0 && sck == $past(cpol)));
endmodule

// File: rtl/spi_wc_flags.sv
module spi_wc_flags (
  input  logic clk,
  input  logic rst,
  input  logic done_set,
  input  logic wcol_set,
  input  logic stat_rd,
  input  logic data_rd,
  output logic done,
  output logic wcol
);
  logic armed, seen_done, seen_wcol, fire;

  assign fire = data_rd && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      seen_done <= 1'b0;
      seen_wcol <= 1'b0;
      done      <= 1'b0;
      wcol      <= 1'b0;
    end else begin
      if (stat_rd) begin
        armed     <= done || wcol;
        seen_done <= done;
        seen_wcol <= wcol;
      end else if (fire) begin
        armed <= 1'b0;
      end
      done <= done_set || (done && !(fire && seen_done));
      wcol <= wcol_set || (wcol && !(fire && seen_wcol));
    end
  end

  // R11: a set in the clearing cycle wins
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    done_set |=> done);
  // R9: only an armed data read lowers the collision flag
  a_r9_write_keeps_wcol: assert property (@(posedge clk) disable iff (rst)
    (wcol && !data_rd) |=> wcol);
  // R8: clearing needs the handshake
  a_r8_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $fell(wcol) |-> $past(data_rd && armed));
endmodule

// File: rtl/spi_wcol_ctrl.sv
module spi_wcol_ctrl import spi_wc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int HALF_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sck_out,
  output logic              mosi_out,
  input  logic              miso_in,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  output logic              miso_out,
  output logic              miso_oe
);
  localparam int CNT_W = $clog2(DATA_W);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] tx_q, rx_sh, rx_buf, stat_v;
  logic [CNT_W-1:0]  bit_cnt;
  logic              s_xfer, sck_prev;
  logic              ss_s, sck_s, mosi_s;
  logic              m_lead, m_trail, m_busy;
  logic              ss_act, s_edge, lead, trail, smp, drv, din;
  logic              busy_win, dwr, drd, srd, collide, load, last_smp;
  logic              done_flag, wcol_flag;

  spi_wc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({ss_n_in, sck_in, mosi_in}), .q({ss_s, sck_s, mosi_s}));

  spi_wc_mclk #(.HALF_DIV(HALF_DIV), .BITS(DATA_W)) u_mclk (
    .clk(clk), .rst(rst), .start(load && ctrl.master), .cpol(ctrl.cpol),
    .sck(sck_out), .lead(m_lead), .trail(m_trail), .busy(m_busy));

  assign ss_act   = !ss_s && !ctrl.master;
  assign s_edge   = ss_act && (sck_s != sck_prev);
  assign lead     = ctrl.master ? m_lead  : (s_edge && (sck_s != ctrl.cpol));
  assign trail    = ctrl.master ? m_trail : (s_edge && (sck_s == ctrl.cpol));
  assign smp      = ctrl.cpha ? trail : lead;
  assign drv      = ctrl.cpha ? lead : trail;
  assign din      = ctrl.master ? miso_in : mosi_s;
  assign busy_win = ctrl.master ? m_busy : (ctrl.cpha ? s_xfer : ss_act);
  assign dwr      = reg_wr && (reg_addr == ADDR_DATA);
  assign drd      = reg_rd && (reg_addr == ADDR_DATA);
  assign srd      = reg_rd && (reg_addr == ADDR_STAT);
  assign collide  = dwr && busy_win;
  assign load     = dwr && !busy_win;
  assign last_smp = smp && (bit_cnt == CNT_W'(DATA_W - 1));

  assign mosi_out = tx_q[DATA_W-1];
  assign miso_out = tx_q[DATA_W-1];
  assign miso_oe  = ss_act && (!ctrl.cpha || s_xfer);

  spi_wc_flags u_flags (
    .clk(clk), .rst(rst), .done_set(last_smp), .wcol_set(collide),
    .stat_rd(srd), .data_rd(drd), .done(done_flag), .wcol(wcol_flag));

  always_comb begin
    stat_v = '0;
    stat_v[STAT_DONE_BIT] = done_flag;
    stat_v[STAT_WCOL_BIT] = wcol_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      tx_q      <= '0;
      rx_sh     <= '0;
      rx_buf    <= '0;
      bit_cnt   <= '0;
      s_xfer    <= 1'b0;
      sck_prev  <= 1'b0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      irq      <= done_flag && ctrl.irq_en;
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[3:0]);

      if (load) tx_q <= reg_wdata;
      else if (drv && !(ctrl.cpha && bit_cnt == '0)) tx_q <= {tx_q[DATA_W-2:0], 1'b0};

      if (!ctrl.master && ss_s) begin
        bit_cnt <= '0;
        s_xfer  <= 1'b0;
      end else if (load && ctrl.master) begin
        bit_cnt <= '0;
      end else begin
        if (s_edge) s_xfer <= 1'b1;
        if (smp) begin
          rx_sh <= {rx_sh[DATA_W-2:0], din};
          if (last_smp) begin
            bit_cnt <= '0;
            rx_buf  <= {rx_sh[DATA_W-2:0], din};
            s_xfer  <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end

      if (reg_rd) begin
        case (reg_addr)
          ADDR_CTRL: reg_rdata <= {{(DATA_W-4){1'b0}}, ctrl};
          ADDR_STAT: reg_rdata <= stat_v;
          ADDR_DATA: reg_rdata <= rx_buf;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  // R3 R4 R5: a colliding write leaves the outgoing byte alone
  a_r3_collide_keeps_tx: assert property (@(posedge clk) disable iff (rst)
    (collide && !drv) |=> tx_q == $past(tx_q));
  // R10: deselected slave never drives MISO
  a_r10_miso_float: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.master && ss_s) |-> !miso_oe);
  // R7: interrupt only follows completion
  a_r7_irq_from_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_flag));
  // R6: eighth sample sets completion
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (rst)
    last_smp |=> done_flag);
endmodule

// File: tb/spi_wcol_ctrl_test.sv
module spi_wcol_ctrl_test;
  localparam int H  = 4;
  localparam int SH = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, sck_out, mosi_out, miso_out, miso_oe;
  logic miso_in = 1'b0, sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;

  int n_chk = 0, n_err = 0;
  logic tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic model_go = 1'b0;
  logic [7:0] mpat = '0, mo_cap = '0;
  int mk = 0;
  logic msck_prev = 1'b0;

  spi_wcol_ctrl #(.DATA_W(8), .HALF_DIV(H), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck_out(sck_out),
    .mosi_out(mosi_out), .miso_in(miso_in), .sck_in(sck_in), .mosi_in(mosi_in),
    .ss_n_in(ss_n_in), .miso_out(miso_out), .miso_oe(miso_oe));

  always #10 clk = ~clk;

  // bench slave answering the master
  always @(negedge clk) begin
    if (model_go) begin
      mk = 0;
      mo_cap = '0;
      miso_in = tb_cpha ? 1'b0 : mpat[7];
    end else if (sck_out != msck_prev) begin
      if ((sck_out != tb_cpol) == !tb_cpha) begin
        mo_cap = {mo_cap[6:0], mosi_out};
      end else if (tb_cpha) begin
        if (mk < 8) miso_in = mpat[7-mk];
        mk++;
      end else begin
        mk++;
        if (mk < 8) miso_in = mpat[7-mk];
      end
    end
    msck_prev = sck_out;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic config_mode(input logic mstr, input logic cpol, input logic cpha);
    tb_cpol = cpol; tb_cpha = cpha;
    wr(A_CTRL, {4'b0, 1'b1, cpha, cpol, mstr});
    sck_in = cpol;
    repeat (4) @(negedge clk);
  endtask

  task automatic master_xfer(input logic [7:0] tp, input logic [7:0] mp);
    mpat = mp;
    model_go = 1'b1;
    repeat (2) @(negedge clk);
    model_go = 1'b0;
    wr(A_DATA, tp);
    repeat (16*H + 4) @(negedge clk);
  endtask

  task automatic half_wait(input bit do_wr, input logic [7:0] wv);
    if (do_wr) begin
      reg_addr = A_DATA; reg_wdata = wv; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (SH-1) @(negedge clk);
    end else begin
      repeat (SH) @(negedge clk);
    end
  endtask

  task automatic sclk(input logic [7:0] mo, input bit mid, input logic [7:0] wv,
                      output logic [7:0] mi);
    for (int i = 0; i < 8; i++) begin
      if (!tb_cpha) begin
        mosi_in = mo[7-i];
        half_wait(mid && i == 3, wv);
        mi[7-i] = miso_out;
        sck_in = ~tb_cpol;
        repeat (SH) @(negedge clk);
        sck_in = tb_cpol;
      end else begin
        sck_in = ~tb_cpol;
        mosi_in = mo[7-i];
        half_wait(mid && i == 3, wv);
        mi[7-i] = miso_out;
        sck_in = tb_cpol;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (SH) @(negedge clk);
  endtask

  task automatic ss_set(input logic v);
    ss_n_in = v;
    repeat (SH) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, mi, tp, mp, sp, mo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", reg_rdata, 0);
    check("R6 reset irq", irq, 0);
    check("R10 reset miso_oe", miso_oe, 0);
    rd(A_STAT, d);
    check("R1 reset status", d, 0);

    // master sweep over all four clock modes
    for (int m = 0; m < 4; m++) begin
      config_mode(1'b1, m[1], m[0]);
      check("R13 idle sck level", sck_out, m[1]);
      rd(A_CTRL, d);
      check("R1 control readback", d, {4'b0, 1'b1, m[0], m[1], 1'b1});
      for (int p = 0; p < 8; p++) begin
        tp = 8'(p*37 + m*11 + 5);
        mp = 8'(p*53 + m*29 + 9) ^ 8'hA5;
        master_xfer(tp, mp);
        check("R2 mosi byte", mo_cap, tp);
        check("R13 sck back idle", sck_out, m[1]);
        check("R6 irq on done", irq, 1);
        rd(A_STAT, d);
        check("R6 done flag", d, 8'h80);
        rd(A_DATA, d);
        check("R2 miso byte", d, mp);
        @(negedge clk);
        check("R6 irq dropped", irq, 0);
        rd(A_STAT, d);
        check("R8 flags cleared", d, 0);
      end
    end

    // master collision during shifting
    config_mode(1'b1, 1'b0, 1'b1);
    mpat = 8'h3C;
    model_go = 1'b1;
    repeat (2) @(negedge clk);
    model_go = 1'b0;
    wr(A_DATA, 8'hC6);
    repeat (10) @(negedge clk);
    wr(A_DATA, 8'h11);
    repeat (16*H) @(negedge clk);
    check("R3 byte on wire kept", mo_cap, 8'hC6);
    rd(A_STAT, d);
    check("R3 collision and done", d, 8'hC0);
    rd(A_DATA, d);
    check("R3 rx intact", d, 8'h3C);
    rd(A_STAT, d);
    check("R8 both cleared", d, 0);

    // same-cycle set and clear of completion
    config_mode(1'b1, 1'b0, 1'b0);
    master_xfer(8'h5A, 8'h81);
    rd(A_STAT, d);
    check("R11 pending done", d, 8'h80);
    wr(A_DATA, 8'h77);
    repeat (15*H - 1) @(negedge clk);
    reg_addr = A_DATA; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    repeat (2*H + 4) @(negedge clk);
    rd(A_STAT, d);
    check("R11 set wins over clear", d, 8'h80);
    rd(A_DATA, d);
    rd(A_STAT, d);
    check("R8 cleared after conflict", d, 0);

    // slave sweep
    for (int m = 0; m < 4; m++) begin
      config_mode(1'b0, m[1], m[0]);
      for (int p = 0; p < 3; p++) begin
        sp = 8'(p*71 + m*13 + 3);
        mo = 8'(p*19 + m*41 + 7) ^ 8'h3C;
        if (!m[0]) begin
          wr(A_DATA, sp);
          ss_set(1'b0);
          check("R10 selected phase0 drives", miso_oe, 1);
        end else begin
          ss_set(1'b0);
          check("R5 undriven before first edge", miso_oe, 0);
          wr(A_DATA, sp);
        end
        sclk(mo, 1'b0, 8'h00, mi);
        check(m[0] ? "R5 slave tx byte" : "R4 slave tx byte", mi, sp);
        ss_set(1'b1);
        check("R10 deselected float", miso_oe, 0);
        rd(A_STAT, d);
        check("R6 slave done no wcol", d, 8'h80);
        rd(A_DATA, d);
        check("R12 slave rx byte", d, mo);
      end
      // collision in the middle of a slave byte
      if (!m[0]) wr(A_DATA, 8'h96);
      ss_set(1'b0);
      if (m[0]) wr(A_DATA, 8'h96);
      sclk(8'h0F, 1'b1, 8'h21, mi);
      check(m[0] ? "R5 slave byte after collision" : "R4 slave byte after collision", mi, 8'h96);
      ss_set(1'b1);
      rd(A_STAT, d);
      check(m[0] ? "R5 collision flagged" : "R4 collision flagged", d, 8'hC0);
      rd(A_DATA, d);
      check("R12 rx after collision", d, 8'h0F);
      rd(A_STAT, d);
      check("R8 slave flags cleared", d, 0);
    end

    // phase 0 slave: write with select low, no interrupt, write does not clear
    config_mode(1'b0, 1'b0, 1'b0);
    wr(A_DATA, 8'hE1);
    ss_set(1'b0);
    wr(A_DATA, 8'h1E);
    repeat (2) @(negedge clk);
    check("R7 no irq on collision", irq, 0);
    ss_set(1'b1);
    rd(A_STAT, d);
    check("R4 select-low write collides", d, 8'h40);
    wr(A_DATA, 8'h44);
    rd(A_STAT, d);
    check("R9 write leaves wcol", d, 8'h40);
    check("R4 select-high write no collision", d, 8'h40);
    rd(A_DATA, d);
    rd(A_STAT, d);
    check("R8 wcol cleared", d, 0);
    check("R7 irq still low", irq, 0);

    summary();
    $finish;
  end
endmodule